// File: doc/BRIEF.md
# Change-of-State Digital Input Port

A read-only digital input peripheral with 48 lines in six 8-bit groups. It sits behind an 8-byte register window with a 3-bit address, a read strobe and a write strobe. Software reads the six input bytes at fixed offsets. Offset 3 is a hole, so the six bytes are not at contiguous offsets. Every line passes through a two-flop synchroniser before it is used.

Each group can be armed for change-of-state detection. A rising or falling edge on any line of an armed group latches that group's flag and raises a level interrupt. One shared register at offset 7 has two roles. A write loads the per-group arm mask. A read returns the latched group flags together with an active-low pending bit, and then clears the flags. This lets an interrupt handler learn which groups moved and acknowledge them in a single access.

The bus is a plain strobe interface with no back-pressure. A read strobe is always accepted, and the read byte appears on `rdata` on the clock edge that samples the strobe. The value is held until the next read.

Top module: `cos_input_port`

## Requirements
- R1: Input group g (lines 8g..8g+7, lowest line in bit 0) reads at byte offset 0, 1, 2, 4, 5, 6 for g = 0..5. The read value is the input as seen through a two-flop synchroniser, and it appears on `rdata` one cycle after the strobe.
- R2: A read of offset 3 returns 0x00.
- R3: A write to offset 7 loads the arm mask from `wdata` bits 0..5, where bit n arms group n. `wdata` bits 6 and 7 are ignored.
- R4: A rising or a falling transition on any line of an armed group sets that group's flag. The flag is seen in bit n of an offset-7 read.
- R5: A transition on a group that is not armed sets no flag and raises no interrupt.
- R6: An offset-7 read returns the flags in bits 0..5 and the inverse of `irq` in bit 6, with bit 7 = 0. The read then clears all flags, so `irq` is low in the next cycle unless a new armed change arrives in the same cycle.
- R7: `irq` is high exactly while any flag is set. A line change on `din` shows on `irq` after the third rising clock edge.
- R8: When an armed change is detected in the same cycle as an offset-7 read, the read returns the older flags and the new flag survives the clear.
- R9: A write to offset 7 clears the flags of every group it disarms. Writing 0 drops `irq` in the next cycle.
- R10: Writes to any offset other than 7 have no effect.
- R11: After reset, the arm mask and flags are 0, `irq` is low and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| din | input | 48 | Asynchronous input lines |
| irq | output | 1 | Level interrupt request, active high |

## Verification
Two functions can meet in one cycle: the clear performed by a status read and the setting of a flag by a freshly detected edge. The bench provokes this by toggling a line of an armed group exactly two edges before it issues the offset-7 read, so that detection and clear share one clock edge. It judges the result by two outcomes: the read returns only the previously latched group, and a second read then shows the new group still pending with `irq` high.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int ADDR_W    = 3;
  localparam int BYTE_W    = 8;
  localparam logic [ADDR_W-1:0] HOLE_ADDR = 3'd3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd7;
  localparam int PEND_BIT  = 6;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } grp_sel_t;

  // Map a register offset onto an input group, stepping over the hole.
  function automatic grp_sel_t addr_to_group(logic [ADDR_W-1:0] a);
    grp_sel_t s;
    s.hit = (a != HOLE_ADDR) && (a != CTRL_ADDR);
    s.idx = (a > HOLE_ADDR) ? a - 3'd1 : a;
    return s;
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cos_change_det.sv
module cos_change_det #(
  parameter int N_GROUPS = 6,
  parameter int GROUP_W  = 8,
  localparam int W       = N_GROUPS * GROUP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        cur,
  output logic [N_GROUPS-1:0] chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  // Any line differing from the previous sample marks its group, both edge senses.
  generate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      assign chg[g] = |(cur[g*GROUP_W +: GROUP_W] ^ prev[g*GROUP_W +: GROUP_W]);
    end
  endgenerate
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int N_GROUPS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_we,
  input  logic [N_GROUPS-1:0] arm_wdata,
  input  logic                clr,
  input  logic [N_GROUPS-1:0] chg,
  output logic [N_GROUPS-1:0] arm,
  output logic [N_GROUPS-1:0] flags,
  output logic                irq
);
  logic [N_GROUPS-1:0] arm_nxt;
  logic [N_GROUPS-1:0] keep;
  logic [N_GROUPS-1:0] set;

  always_comb begin
    arm_nxt = arm_we ? arm_wdata : arm;
    keep    = clr ? '0 : flags;
    set     = chg & arm;          // new events only from groups already armed
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm   <= '0;
      flags <= '0;
    end else begin
      arm   <= arm_nxt;
      flags <= (keep | set) & arm_nxt;   // set beats clear; disarm drops flags
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
  import cos_pkg::*;
#(
  parameter int N_GROUPS = 6,
  parameter int GROUP_W  = 8,
  localparam int W       = N_GROUPS * GROUP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [W-1:0]        lines,
  input  logic [N_GROUPS-1:0] flags,
  input  logic                irq,
  output logic [BYTE_W-1:0]   rdata
);
  logic [GROUP_W-1:0] grp_val [N_GROUPS];
  logic [BYTE_W-1:0]  rd_nxt;
  grp_sel_t           sel;

  generate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_split
      assign grp_val[g] = lines[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  always_comb begin
    sel    = addr_to_group(addr);
    rd_nxt = '0;
    if (addr == CTRL_ADDR) begin
      rd_nxt[N_GROUPS-1:0] = flags;
      rd_nxt[PEND_BIT]     = ~irq;
    end else if (sel.hit && (int'(sel.idx) < N_GROUPS)) begin
      rd_nxt[GROUP_W-1:0] = grp_val[sel.idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= rd_nxt;
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_pkg::*;
#(
  parameter int N_GROUPS    = 6,
  parameter int GROUP_W     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int W          = N_GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [W-1:0]      din,
  output logic              irq
);
  logic [W-1:0]        lines_s;
  logic [N_GROUPS-1:0] grp_chg;
  logic [N_GROUPS-1:0] cos_arm;
  logic [N_GROUPS-1:0] grp_flags;
  logic                ctrl_wr;
  logic                ctrl_rd;
  logic                unused_wbits;

  assign ctrl_wr      = wr_stb && (addr == CTRL_ADDR);
  assign ctrl_rd      = rd_stb && (addr == CTRL_ADDR);
  assign unused_wbits = ^wdata[7:N_GROUPS];

  cos_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(lines_s)
  );

  cos_change_det #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(lines_s), .chg(grp_chg)
  );

  cos_status #(.N_GROUPS(N_GROUPS)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .arm_we(ctrl_wr), .arm_wdata(wdata[N_GROUPS-1:0]),
    .clr(ctrl_rd), .chg(grp_chg),
    .arm(cos_arm), .flags(grp_flags), .irq(irq)
  );

  cos_rd_mux #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(addr),
    .lines(lines_s), .flags(grp_flags), .irq(irq), .rdata(rdata)
  );
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   addr,
  input logic         rd_stb,
  input logic         wr_stb,
  input logic [7:0]   wdata,
  input logic [7:0]   rdata,
  input logic         irq,
  input logic [N-1:0] arm,
  input logic [N-1:0] flags,
  input logic [N-1:0] chg
);
  p_hole_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd3) |=> (rdata == 8'h00));

  p_status_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd7) |=> (rdata[7] == 1'b0 && rdata[6] == !$past(irq)));

  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd7 && !wr_stb && (chg & arm) == '0) |=> !irq);

  p_no_set_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags & ~$past(flags) & ~$past(arm)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == 3'd7 && !wr_stb && (chg & arm) != '0) |=> irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((chg & arm) != '0));

  p_disarm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 3'd7 && wdata[N-1:0] == '0) |=> !irq);

  p_other_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr != 3'd7) |=> $stable(arm));
endmodule

bind cos_input_port cos_input_port_chk #(.N(N_GROUPS)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .wdata(wdata), .rdata(rdata), .irq(irq),
  .arm(cos_arm), .flags(grp_flags), .chg(grp_chg)
);

// File: tb/cos_input_port_tb_top.sv
module cos_input_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] din = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_input_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .din(din), .irq(irq)
  );

  always @(posedge clk) pend <= rd_stb;

  // Monitor: pops one expected byte per completed read.
  initial forever begin
    @(negedge clk);
    if (pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  // Called at a negedge; returns at the next negedge.
  task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_irq(1'b0, "R11");
    total++;
    if (rdata !== 8'h00) begin bad++; $display("FAIL R11: rdata actual=%02h expected=00", rdata); end
    do_read(3'd7, 8'h40, "R11 status after reset");

    // R1 input mapping, two patterns
    din = 48'hA55AC33C0FF0; settle();
    do_read(3'd0, 8'hF0, "R1 g0"); do_read(3'd1, 8'h0F, "R1 g1");
    do_read(3'd2, 8'h3C, "R1 g2"); do_read(3'd4, 8'hC3, "R1 g3");
    do_read(3'd5, 8'h5A, "R1 g4"); do_read(3'd6, 8'hA5, "R1 g5");
    din = 48'h010204081080; settle();
    do_read(3'd0, 8'h80, "R1 g0 b"); do_read(3'd4, 8'h04, "R1 g3 b");
    do_read(3'd6, 8'h01, "R1 g5 b");
    // R2 hole
    do_read(3'd3, 8'h00, "R2 hole");

    // R10 writes elsewhere ignored
    do_write(3'd0, 8'hFF); do_write(3'd5, 8'h3F); do_write(3'd3, 8'h3F);
    din[0] = ~din[0]; settle();
    check_irq(1'b0, "R10");
    do_read(3'd7, 8'h40, "R10 status");
    do_read(3'd0, 8'h81, "R10 input unchanged by write");

    // R3 / R4 arm group 0 with junk in bits 6,7; rising then falling edge
    do_write(3'd7, 8'hC1);
    din[3] = 1'b1; settle();
    check_irq(1'b1, "R4 rise R7");
    do_read(3'd7, 8'h01, "R3 R4 rise status");
    check_irq(1'b0, "R6 clear");
    do_read(3'd7, 8'h40, "R6 status after clear");
    din[3] = 1'b0; settle();
    do_read(3'd7, 8'h01, "R4 fall status");

    // R5 disarmed group
    din[16] = ~din[16]; settle();
    check_irq(1'b0, "R5");
    do_read(3'd7, 8'h40, "R5 status");

    // Two groups at once
    do_write(3'd7, 8'h3F);
    din[8] = ~din[8]; din[40] = ~din[40]; settle();
    do_read(3'd7, 8'h22, "R4 two groups");

    // R7 latency: three edges
    din[32] = ~din[32];
    repeat (2) @(posedge clk); @(negedge clk);
    check_irq(1'b0, "R7 after two edges");
    @(posedge clk); @(negedge clk);
    check_irq(1'b1, "R7 after three edges");
    do_read(3'd7, 8'h10, "R7 status");

    // R8 collision of read-clear and new detection
    din[24] = ~din[24]; settle();
    din[0] = ~din[0];
    repeat (2) @(posedge clk); @(negedge clk);
    do_read(3'd7, 8'h08, "R8 older flags");
    check_irq(1'b1, "R8 survivor");
    do_read(3'd7, 8'h01, "R8 new flag");
    check_irq(1'b0, "R8 cleared");

    // R9 disarm clears flags
    din[8] = ~din[8]; din[32] = ~din[32]; settle();
    do_write(3'd7, 8'h02);
    do_read(3'd7, 8'h02, "R9 partial disarm");
    do_write(3'd7, 8'h3F);
    din[16] = ~din[16]; settle();
    check_irq(1'b1, "R9 armed");
    do_write(3'd7, 8'h00);
    check_irq(1'b0, "R9 write zero");
    do_read(3'd7, 8'h40, "R9 status");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule